// File: doc/BRIEF.md
# Edge/Level Interrupt Collector

The block gathers up to 32 interrupt request lines into a single interrupt output for a firmware processor. The lower 16 lines come from sources inside the subsystem. They are always treated as rising-edge, active-high events. The remaining lines, up to 16, come from outside the subsystem. For each of these, a parameter selects the active polarity and another selects edge or level behaviour.

Every line is first brought to an active-high form. A line in edge mode records an event when it goes from inactive to active. A line in level mode records an event in every cycle it is active. Events are held in a sticky status register. They are masked by an enable register, and the output is raised whenever any enabled status bit is set. Firmware clears events by writing ones to an acknowledge register. A level line that is still active is recorded again in the same cycle as the acknowledge, so it cannot be lost.

Firmware reaches the block through a plain 32-bit register port with a one-cycle read latency.

Top module: `irq_collector`

## Requirements
- R1: After a synchronous reset, the status, enable and pending registers read zero and `irq_o` is low.
- R2: Line N maps to bit N of every register. Lines 0 to 15 are internal and lines 16 up to 15+EXT_COUNT are external. A line at index 16+EXT_COUNT or above never sets a status bit and cannot be enabled, so enable reads zero there.
- R3: An external line whose polarity parameter bit is 0 is active-low: driving it to 0 records an event, and holding it at 1 records none. Internal lines are always active-high.
- R4: A line in edge mode (all internal lines, and external lines whose mode bit is 1) sets its status bit only on an inactive-to-active change. Staying active after an acknowledge does not set the bit again.
- R5: A line in level mode (external lines whose mode bit is 0) sets its status bit in every cycle it is active.
- R6: Status bits are sticky: once set, a bit stays set after its line goes inactive, until it is acknowledged.
- R7: Pending (offset 0x34) reads as status AND enable. `irq_o` is high exactly when pending is non-zero, and it follows a new input event on the same clock edge that sets the status bit.
- R8: Writing the acknowledge register (offset 0x3C) clears each status bit written as 1 and leaves bits written as 0 unchanged. A level-mode line that is still active sets its bit again on that same edge.
- R9: A write to enable (offset 0x38) takes effect on `irq_o` at the clock edge of the write.
- R10: Reads return the addressed register one cycle after the address is presented. Status (offset 0x30) and pending are read-only, and writes to them have no effect. Acknowledge and any unmapped offset read zero.
- R11: The edge detector's history resets to the inactive level, so an edge-mode line that is already active when reset is released records one event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw interrupt lines, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, one cycle after the address |
| irq_o | output | 1 | Combined interrupt output, registered |

## Verification
Several properties are checked on every cycle. The output always agrees with the stored status and enable. Status bits never fall without an acknowledge. A status bit in edge mode rises only after a detected transition. A level line that is active is always recorded on the next edge, including across an acknowledge. Acknowledge reads always return zero. Only the directed scenarios can show the end-to-end behaviour: polarity inversion on specific lines, lines beyond the configured count being ignored, writes to the read-only registers having no effect, the cycle in which an enable write reaches the output, and the single event seen after reset while an edge line is held active.

// File: rtl/irq_col_pkg.sv
package irq_col_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned INT_LINES  = 16;
  localparam int unsigned OFF_STATUS = 32'h30;
  localparam int unsigned OFF_PEND   = 32'h34;
  localparam int unsigned OFF_ENABLE = 32'h38;
  localparam int unsigned OFF_ACK    = 32'h3C;

  // Mask of implemented lines: 16 internal plus up to 16 external.
  function automatic logic [REG_W-1:0] line_mask(input int unsigned ext_count);
    if (ext_count >= 16) return '1;
    return (REG_W'(1) << (INT_LINES + ext_count)) - REG_W'(1);
  endfunction
endpackage

// File: rtl/irq_col_front.sv
module irq_col_front #(
  parameter logic [31:0] EDGE_MODE = 32'h0000FFFF,
  parameter logic [31:0] ACT_HIGH  = 32'h0000FFFF,
  parameter logic [31:0] VALID     = 32'h0000FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] src_i,
  output logic [31:0] norm_o,
  output logic [31:0] evt_o
);
  logic [31:0] norm;
  logic [31:0] prev_q;

  // Active-low lines are inverted; unimplemented lines are tied inactive.
  assign norm   = (src_i ^ ~ACT_HIGH) & VALID;
  assign norm_o = norm;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= norm;
  end

  for (genvar i = 0; i < 32; i++) begin : g_line
    if (EDGE_MODE[i]) begin : g_edge
      assign evt_o[i] = norm[i] & ~prev_q[i];
    end else begin : g_level
      assign evt_o[i] = norm[i];
    end
  end
endmodule

// File: rtl/irq_col_core.sv
module irq_col_core #(
  parameter logic [31:0] EDGE_MODE = 32'h0000FFFF,
  parameter logic [31:0] VALID     = 32'h0000FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] evt_i,
  input  logic [31:0] norm_i,
  input  logic        en_wr_i,
  input  logic        ack_wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] status_o,
  output logic [31:0] enable_o,
  output logic        irq_o
);
  logic [31:0] status_q, enable_q, status_n, enable_n, ack_bits;
  logic        irq_q;

  assign ack_bits = ack_wr_i ? wdata_i : '0;
  // Clear first, then OR in events: active level lines re-latch at once.
  assign status_n = ((status_q & ~ack_bits) | evt_i) & VALID;
  assign enable_n = en_wr_i ? (wdata_i & VALID) : enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      enable_q <= enable_n;
      irq_q    <= |(status_n & enable_n);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  a_r7_irq_tracks_pending: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(status_q & enable_q));

  a_r6_status_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ack_wr_i)) |->
      ((status_q & $past(status_q)) == $past(status_q)));

  a_r8_level_relatched: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      ((status_q & $past(norm_i & ~EDGE_MODE)) == $past(norm_i & ~EDGE_MODE)));

  a_r4_edge_needs_event: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      ((status_q & ~$past(status_q) & EDGE_MODE & ~$past(evt_i)) == 32'h0));
endmodule

// File: rtl/irq_col_regs.sv
module irq_col_regs
  import irq_col_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       status_i,
  input  logic [31:0]       enable_i,
  output logic              en_wr_o,
  output logic              ack_wr_o,
  output logic [31:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);

  logic [31:0] rdata_q;

  assign en_wr_o  = wr_en_i && (addr_i == A_ENABLE);
  assign ack_wr_o = wr_en_i && (addr_i == A_ACK);

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (addr_i)
        A_STATUS: rdata_q <= status_i;
        A_PEND:   rdata_q <= status_i & enable_i;
        A_ENABLE: rdata_q <= enable_i;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  a_r10_ack_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr_i) == A_ACK) |-> (rdata_q == 32'h0));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_col_pkg::*;
#(
  parameter int unsigned EXT_COUNT    = 8,
  parameter logic [15:0] EXT_EDGE     = 16'h000F,
  parameter logic [15:0] EXT_ACT_HIGH = 16'h00D5,
  parameter int unsigned ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  // Internal lines are forced to edge mode and active-high.
  localparam logic [31:0] EDGE_FULL = {EXT_EDGE, 16'hFFFF};
  localparam logic [31:0] POS_FULL  = {EXT_ACT_HIGH, 16'hFFFF};
  localparam logic [31:0] VALID     = line_mask(EXT_COUNT);

  logic [31:0] norm, evt, status, enable;
  logic        en_wr, ack_wr;

  irq_col_front #(.EDGE_MODE(EDGE_FULL), .ACT_HIGH(POS_FULL), .VALID(VALID)) front_i (
    .clk(clk), .rst(rst), .src_i(src_i), .norm_o(norm), .evt_o(evt)
  );

  irq_col_core #(.EDGE_MODE(EDGE_FULL), .VALID(VALID)) core_i (
    .clk(clk), .rst(rst), .evt_i(evt), .norm_i(norm),
    .en_wr_i(en_wr), .ack_wr_i(ack_wr), .wdata_i(wdata_i),
    .status_o(status), .enable_o(enable), .irq_o(irq_o)
  );

  irq_col_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .status_i(status), .enable_i(enable),
    .en_wr_o(en_wr), .ack_wr_o(ack_wr), .rdata_o(rdata_o)
  );
endmodule

// File: tb/irq_collector_tb_top.sv
module irq_collector_tb_top;
  // Defaults: EXT_COUNT=8 (lines 0..23), external 16..19 edge, 20..23 level,
  // active-low lines 17, 19, 21.
  localparam logic [31:0] IDLE = 32'h002A0000;
  localparam logic [7:0] A_ST = 8'h30, A_PD = 8'h34, A_EN = 8'h38, A_AK = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = IDLE;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_collector dut_i (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(posedge clk); #1 d = rdata; addr = 8'h00;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); src = v;
    @(posedge clk); #1;
  endtask

  task automatic clean();
    drive(IDLE);
    wr(A_AK, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ST, v); chk("R1 status", v, 0);
    rd(A_EN, v); chk("R1 enable", v, 0);
    rd(A_PD, v); chk("R1 pending", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_internal_edge();
    logic [31:0] v;
    clean();
    drive(IDLE | 32'h8);
    rd(A_ST, v); chk("R4 internal rise sets bit3", v, 32'h8);
    wr(A_AK, 32'h8);
    drive(IDLE | 32'h8);
    rd(A_ST, v); chk("R4 held edge line not re-latched", v, 0);
    drive(IDLE);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    clean();
    drive(IDLE & ~32'h0002_0000);
    rd(A_ST, v); chk("R3 active-low line17", v, 32'h0002_0000);
    drive(IDLE);
    rd(A_ST, v); chk("R6 sticky after release", v, 32'h0002_0000);
    clean();
    drive(IDLE & ~32'h0020_0000);
    rd(A_ST, v); chk("R3 active-low level line21", v, 32'h0020_0000);
    drive(IDLE);
  endtask

  task automatic t_level();
    logic [31:0] v;
    clean();
    drive(IDLE | 32'h0010_0000);
    rd(A_ST, v); chk("R5 level line20 sets", v, 32'h0010_0000);
    wr(A_AK, 32'h0010_0000);
    rd(A_ST, v); chk("R8 level still active re-latched", v, 32'h0010_0000);
    drive(IDLE);
    rd(A_ST, v); chk("R6 level sticky after drop", v, 32'h0010_0000);
    wr(A_AK, 32'h0010_0000);
    rd(A_ST, v); chk("R8 ack clears inactive level", v, 0);
  endtask

  task automatic t_enable_irq();
    logic [31:0] v;
    clean();
    drive(IDLE | 32'h0001_0000); drive(IDLE);
    chk("R7 masked event no irq", {31'b0, irq}, 0);
    wr(A_EN, 32'h0001_0000);
    chk("R9 enable write raises irq at once", {31'b0, irq}, 1);
    drive(IDLE | 32'h0000_0008); drive(IDLE);
    rd(A_PD, v); chk("R7 pending is status&enable", v, 32'h0001_0000);
    rd(A_ST, v); chk("R8 ack bits written 0 kept", v, 32'h0001_0008);
    wr(A_AK, 32'h0000_0008);
    rd(A_ST, v); chk("R8 partial ack", v, 32'h0001_0000);
    wr(A_EN, 32'h0);
    chk("R9 enable clear drops irq", {31'b0, irq}, 0);
    wr(A_EN, 32'h0004_0000);
    drive(IDLE | 32'h0004_0000);
    chk("R7 irq on event edge", {31'b0, irq}, 1);
    drive(IDLE);
    wr(A_AK, 32'h0004_0000);
    chk("R7 irq low after ack", {31'b0, irq}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    clean();
    drive(IDLE | 32'h0001_0000); drive(IDLE);
    wr(A_ST, 32'h0);
    wr(A_PD, 32'h0);
    rd(A_ST, v); chk("R10 status read-only", v, 32'h0001_0000);
    rd(A_AK, v); chk("R10 ack reads zero", v, 0);
    rd(8'h10, v); chk("R10 unmapped reads zero", v, 0);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); chk("R2 enable only implemented lines", v, 32'h00FF_FFFF);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    clean();
    drive(IDLE | 32'h1100_0000); drive(IDLE);
    rd(A_ST, v); chk("R2 lines beyond count ignored", v, 0);
  endtask

  task automatic t_reset_edge();
    logic [31:0] v;
    @(negedge clk); rst = 1'b1; src = IDLE | 32'h20;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    rd(A_ST, v); chk("R11 edge line active at reset release", v, 32'h20);
    drive(IDLE);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_internal_edge();
    t_polarity();
    t_level();
    t_enable_irq();
    t_regmap();
    t_unused();
    t_reset_edge();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule